// File: doc/BRIEF.md
# SPI Wiper Register Controller

This block is a serial slave that holds the position code of a digitally controlled resistor ladder. A host sends 16-bit frames on a four-wire SPI bus. Each frame carries an opcode, a register address and one data byte. A frame can write the wiper position register or the mode register, or read either of them back. The block oversamples the SPI clock, chip select and data input with a faster system clock. It therefore needs no clock of its own on the serial side.

The block drives out the current wiper code and a one-hot tap select vector, with one bit for each ladder position. The analog switch array is built from this vector. While chip select is high, the block raises a standby flag and releases its serial output.

After reset the block stays locked until it has seen chip select go from high to low. Until then it ignores all bus traffic.

A mode register bit sets how the read data leaves the block. In push-pull mode both levels are driven. In open-drain mode the output only pulls low, and an external resistor supplies the high level.

Top module: `wiper_spi_ctrl`

## Requirements
- R1: A frame is 16 bits, sent most significant bit first. The data input is sampled on rising edges of the serial clock while chip select is low. The first byte is the header: bits [7:4] hold the opcode (0001 read, 0010 write) and bits [3:0] hold the address (0 wiper register, 1 mode register). The second byte is the data.
- R2: A valid write frame updates the addressed register after the 16th rising clock edge, while chip select is still low.
- R3: If chip select rises before the 16th rising edge, the frame is dropped and no register changes.
- R4: In a read frame, the serial output changes on falling clock edges. The first falling edge after the 8th rising edge presents data bit 7, and the following falling edges present the lower bits in turn.
- R5: Bit 1 of the mode register selects the output type: 0 for push-pull, 1 for open-drain. The reset value gives push-pull.
- R6: In open-drain mode, the output enable is asserted only for a 0 data bit, and the output level is then low. In push-pull mode, the output enable is asserted for every data bit and the output level equals the bit.
- R7: While chip select is high, the output enable is deasserted and the standby flag is high. While chip select is low, the standby flag is low.
- R8: After reset, all serial traffic is ignored until a high-to-low transition of chip select has been observed.
- R9: After reset, the wiper register holds 128 and the mode register holds 0.
- R10: A frame with an undefined opcode or an undefined address changes no register. The output enable stays deasserted for the whole of that frame.
- R11: The tap select vector is one-hot, and its set bit has the index equal to the wiper code. Code 255 selects the top tap, next to the high terminal, and code 0 selects the bottom tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data level |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high impedance |
| standby | output | 1 | High while chip select is deasserted |
| wiper_code | output | DATA_W | Current wiper position code |
| tap_sel | output | 2**DATA_W | One-hot ladder tap select |

## Verification
The bench first clocks a full write frame before chip select has ever fallen. A design that arms itself out of reset would move the wiper away from 128 at that point.

Frames cut short after 12 and 15 bits catch a commit that happens too early. Such a design would load a partial byte into the wiper.

Frames with an undefined opcode or an undefined address expose a decoder that is too loose. Such a design would drive the output or overwrite a register.

Reads of patterned bytes are made in both output modes, which catches swapped enable polarity and bit-order errors. The extreme codes 0 and 255 check that the tap vector is not mirrored or shifted by one.

// File: rtl/wspi_pkg.sv
package wspi_pkg;
   localparam int OP_W   = 4;
   localparam int ADDR_W = 4;

   typedef enum logic [OP_W-1:0] {
      OPC_READ  = 4'b0001,
      OPC_WRITE = 4'b0010
   } opc_e;

   localparam logic [ADDR_W-1:0] ADR_WIPER = 4'd0;
   localparam logic [ADDR_W-1:0] ADR_MODE  = 4'd1;

   typedef struct packed {
      logic [OP_W-1:0]   opc;
      logic [ADDR_W-1:0] adr;
   } hdr_t;
endpackage

// File: rtl/wspi_sync.sv
module wspi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("wspi_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wspi_frame.sv
module wspi_frame
   import wspi_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              cs_hi,
   input  logic              cs_fall,
   input  logic              mosi_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [ADDR_W-1:0] rd_adr_o,
   output logic              armed_o,
   output logic              wr_stb_o,
   output logic [ADDR_W-1:0] wr_adr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              tx_bit_o,
   output logic              tx_en_o
);
   localparam int HDR_W   = OP_W + ADDR_W;
   localparam int FRAME_W = HDR_W + DATA_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_HDR   = CNT_W'(HDR_W - 1);
   localparam logic [CNT_W-1:0] CNT_DATA0 = CNT_W'(HDR_W);
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_W);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("wspi_frame needs DATA_W of at least 2");
      end
   endgenerate

   logic [FRAME_W-2:0] sh_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               armed_q, rd_act_q, tx_en_q, tx_bit_q, wr_stb_q;
   logic [DATA_W-1:0]  tx_sh_q, wr_data_q;
   logic [ADDR_W-1:0]  wr_adr_q;
   logic [FRAME_W-1:0] word_nx;
   hdr_t               hdr_now, hdr_full;
   logic               take;

   function automatic logic adr_known(input logic [ADDR_W-1:0] a);
      return (a == ADR_WIPER) || (a == ADR_MODE);
   endfunction

   assign word_nx  = {sh_q, mosi_i};
   assign hdr_now  = hdr_t'(word_nx[HDR_W-1:0]);
   assign hdr_full = hdr_t'(word_nx[FRAME_W-1:DATA_W]);
   assign take     = sck_rise & armed_q & ~cs_hi & (cnt_q != CNT_FULL);
   assign rd_adr_o = hdr_now.adr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= '0;
         cnt_q     <= '0;
         armed_q   <= 1'b0;
         rd_act_q  <= 1'b0;
         tx_en_q   <= 1'b0;
         tx_bit_q  <= 1'b0;
         tx_sh_q   <= '0;
         wr_stb_q  <= 1'b0;
         wr_adr_q  <= '0;
         wr_data_q <= '0;
      end else begin
         wr_stb_q <= 1'b0;
         if (cs_hi) begin
            cnt_q    <= '0;
            rd_act_q <= 1'b0;
            tx_en_q  <= 1'b0;
         end else begin
            if (cs_fall) armed_q <= 1'b1;
            if (take) begin
               sh_q  <= word_nx[FRAME_W-2:0];
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_HDR && hdr_now.opc == OPC_READ && adr_known(hdr_now.adr)) begin
                  rd_act_q <= 1'b1;
                  tx_sh_q  <= rd_data_i;
               end
               if (cnt_q == CNT_LAST && hdr_full.opc == OPC_WRITE && adr_known(hdr_full.adr)) begin
                  wr_stb_q  <= 1'b1;
                  wr_adr_q  <= hdr_full.adr;
                  wr_data_q <= word_nx[DATA_W-1:0];
               end
            end
            if (sck_fall && rd_act_q) begin
               if (cnt_q >= CNT_DATA0 && cnt_q <= CNT_LAST) begin
                  tx_bit_q <= tx_sh_q[DATA_W-1];
                  tx_sh_q  <= {tx_sh_q[DATA_W-2:0], 1'b0};
                  tx_en_q  <= 1'b1;
               end else begin
                  tx_en_q  <= 1'b0;
               end
            end
         end
      end
   end

   assign armed_o   = armed_q;
   assign wr_stb_o  = wr_stb_q;
   assign wr_adr_o  = wr_adr_q;
   assign wr_data_o = wr_data_q;
   assign tx_bit_o  = tx_bit_q;
   assign tx_en_o   = tx_en_q;

   // R2: a commit is only issued once the whole frame has been counted
   a_r2_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_q |-> (cnt_q == CNT_FULL));
   // R8: no bit is counted before the bus has been armed
   a_r8_idle_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> (cnt_q == '0));
   // R4: data is only presented after the header has been received
   a_r4_drive_after_hdr: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en_q |-> (cnt_q >= CNT_DATA0));
   // R10: the output is only enabled inside a decoded read
   a_r10_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en_q |-> rd_act_q);
endmodule

// File: rtl/wspi_regs.sv
module wspi_regs
   import wspi_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int WIPER_RST = 128,
   parameter int MODE_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed_i,
   input  logic              wr_stb_i,
   input  logic [ADDR_W-1:0] wr_adr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_adr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [DATA_W-1:0] wiper_o,
   output logic              od_o
);
   localparam logic [DATA_W-1:0] WIPER_INIT = DATA_W'(WIPER_RST);

   generate
      if (WIPER_RST < 0 || WIPER_RST >= (1 << DATA_W)) begin : g_bad_rst
         $error("wspi_regs WIPER_RST does not fit DATA_W");
      end
      if (MODE_BIT < 0 || MODE_BIT >= DATA_W) begin : g_bad_mode
         $error("wspi_regs MODE_BIT outside the register");
      end
   endgenerate

   logic [DATA_W-1:0] wiper_q, mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wiper_q <= WIPER_INIT;
         mode_q  <= '0;
      end else if (wr_stb_i) begin
         if (wr_adr_i == ADR_WIPER) wiper_q <= wr_data_i;
         if (wr_adr_i == ADR_MODE)  mode_q  <= wr_data_i;
      end
   end

   always_comb begin
      case (rd_adr_i)
         ADR_WIPER: rd_data_o = wiper_q;
         ADR_MODE:  rd_data_o = mode_q;
         default:   rd_data_o = '0;
      endcase
   end

   assign wiper_o = wiper_q;
   assign od_o    = mode_q[MODE_BIT];

   // R8: registers cannot move while the bus is still locked
   a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_i |=> ($stable(wiper_q) && $stable(mode_q)));
   // R3: without a commit strobe nothing changes
   a_r3_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb_i |=> ($stable(wiper_q) && $stable(mode_q)));
endmodule

// File: rtl/wspi_tap_dec.sv
module wspi_tap_dec #(
   parameter int CODE_W  = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CODE_W-1:0]       code_i,
   output logic [(1<<CODE_W)-1:0]  tap_o
);
   localparam int N_TAP = 1 << CODE_W;

   logic [N_TAP-1:0] hot;

   generate
      for (genvar i = 0; i < N_TAP; i++) begin : g_tap
         assign hot[i] = (code_i == CODE_W'(i));
      end

      if (REG_OUT) begin : g_reg
         logic [N_TAP-1:0] tap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tap_q <= '0;
            else        tap_q <= hot;
         end
         assign tap_o = tap_q;
      end else begin : g_comb
         assign tap_o = hot;
      end
   endgenerate

   // R11: exactly one tap, the one addressed by the code
   a_r11_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(hot) == 1) && hot[code_i]);
   // R11: top code lands on the tap next to the high terminal
   a_r11_top_end: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == {CODE_W{1'b1}}) |-> hot[N_TAP-1]);
endmodule

// File: rtl/wiper_spi_ctrl.sv
module wiper_spi_ctrl
   import wspi_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int WIPER_RST   = 128,
   parameter int MODE_BIT    = 1,
   parameter bit TAP_REG     = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    spi_sck,
   input  logic                    spi_cs_n,
   input  logic                    spi_mosi,
   output logic                    spi_miso,
   output logic                    spi_miso_oe,
   output logic                    standby,
   output logic [DATA_W-1:0]       wiper_code,
   output logic [(1<<DATA_W)-1:0]  tap_sel
);
   logic sck_s, cs_s, mosi_s;
   logic sck_prev_q, cs_prev_q;
   logic sck_rise, sck_fall, cs_fall;
   logic armed, wr_stb, tx_bit, tx_en, od_mode;
   logic [ADDR_W-1:0] wr_adr, rd_adr;
   logic [DATA_W-1:0] wr_data, rd_data;

   wspi_sync #(.STAGES(SYNC_STAGES)) u_sync_sck
      (.clk(clk), .rst_n(rst_n), .d_i(spi_sck),  .q_o(sck_s));
   wspi_sync #(.STAGES(SYNC_STAGES)) u_sync_cs
      (.clk(clk), .rst_n(rst_n), .d_i(spi_cs_n), .q_o(cs_s));
   wspi_sync #(.STAGES(SYNC_STAGES)) u_sync_mosi
      (.clk(clk), .rst_n(rst_n), .d_i(spi_mosi), .q_o(mosi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev_q <= 1'b0;
         cs_prev_q  <= 1'b0;
      end else begin
         sck_prev_q <= sck_s;
         cs_prev_q  <= cs_s;
      end
   end

   assign sck_rise = sck_s & ~sck_prev_q;
   assign sck_fall = ~sck_s & sck_prev_q;
   assign cs_fall  = ~cs_s & cs_prev_q;

   wspi_frame #(.DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .sck_rise(sck_rise), .sck_fall(sck_fall),
      .cs_hi(cs_s), .cs_fall(cs_fall), .mosi_i(mosi_s),
      .rd_data_i(rd_data), .rd_adr_o(rd_adr),
      .armed_o(armed), .wr_stb_o(wr_stb), .wr_adr_o(wr_adr), .wr_data_o(wr_data),
      .tx_bit_o(tx_bit), .tx_en_o(tx_en)
   );

   wspi_regs #(.DATA_W(DATA_W), .WIPER_RST(WIPER_RST), .MODE_BIT(MODE_BIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .armed_i(armed),
      .wr_stb_i(wr_stb), .wr_adr_i(wr_adr), .wr_data_i(wr_data),
      .rd_adr_i(rd_adr), .rd_data_o(rd_data),
      .wiper_o(wiper_code), .od_o(od_mode)
   );

   wspi_tap_dec #(.CODE_W(DATA_W), .REG_OUT(TAP_REG)) u_tap (
      .clk(clk), .rst_n(rst_n), .code_i(wiper_code), .tap_o(tap_sel)
   );

   assign spi_miso    = od_mode ? 1'b0 : tx_bit;
   assign spi_miso_oe = tx_en & (~od_mode | ~tx_bit);
   assign standby     = cs_s;

   // R7: deselect releases the output line
   a_r7_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !spi_miso_oe);
   // R6: in open-drain mode an enabled output only ever pulls low
   a_r6_od_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
      (od_mode && spi_miso_oe) |-> !spi_miso);
   // R5: push-pull mode drives every data bit
   a_r5_pp_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (!od_mode && tx_en) |-> spi_miso_oe);
endmodule

// File: tb/sim_wiper_spi_ctrl.sv
`timescale 1ns/1ps
module sim_wiper_spi_ctrl;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b0, mosi = 1'b0;
   logic miso, miso_oe, standby;
   logic [7:0]   wiper_code;
   logic [255:0] tap_sel;

   int checks = 0, errors = 0;
   int exp_wiper = 128;
   bit settled = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wiper_spi_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .standby(standby),
      .wiper_code(wiper_code), .tap_sel(tap_sel)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // behavioural reference compared on every clock once the bus is quiet
   always @(negedge clk) begin
      if (settled && rst_n && !done) begin
         chk(wiper_code == exp_wiper[7:0], "R2 wiper code", int'(wiper_code), exp_wiper);
         chk(($countones(tap_sel) == 1) && tap_sel[exp_wiper[7:0]], "R11 tap vector",
             $countones(tap_sel), 1);
         chk(standby == cs_n, "R7 standby", int'(standby), int'(cs_n));
         if (cs_n) chk(!miso_oe, "R7 release", int'(miso_oe), 0);
      end
   end

   task automatic settle(input int w);
      exp_wiper = w;
      settled = 1'b1;
   endtask

   // one frame of nbits; drive/od/rexp describe the expected output during data bits
   task automatic xfer(input logic [15:0] w, input int nbits, input bit toggle_cs,
                       input bit drive, input bit od, input logic [7:0] rexp, input string req);
      settled = 1'b0;
      if (toggle_cs) begin
         cs_n = 1'b0;
         wclk(HALF);
      end
      for (int i = 0; i < nbits; i++) begin
         mosi = w[15-i];
         wclk(HALF);
         if (i >= 8) begin
            logic b;
            b = rexp[15-i];
            if (!drive)
               chk(!miso_oe, req, int'(miso_oe), 0);
            else if (od)
               chk((miso_oe == !b) && (!miso_oe || !miso), req, int'({miso_oe, miso}), int'({!b, 1'b0}));
            else
               chk(miso_oe && (miso == b), req, int'({miso_oe, miso}), int'({1'b1, b}));
         end
         sck = 1'b1;
         wclk(HALF);
         sck = 1'b0;
      end
      wclk(HALF);
      if (toggle_cs) cs_n = 1'b1;
      wclk(8);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      wclk(5);
      rst_n = 1'b1;
      wclk(6);
      // R9 reset values, R7 standby low with chip select low, R11 mid tap
      chk(wiper_code == 8'd128, "R9 wiper reset", int'(wiper_code), 128);
      chk(!miso_oe, "R7 output idle", int'(miso_oe), 0);
      chk(standby == 1'b0, "R7 standby low", int'(standby), 0);
      chk(tap_sel[128] == 1'b1, "R11 mid tap", int'(tap_sel[128]), 1);
      settle(128);

      // R8: full write clocked before any chip select fall is ignored
      xfer(16'h20_33, 16, 1'b0, 1'b0, 1'b0, 8'h00, "R8 locked");
      cs_n = 1'b1;
      wclk(8);
      settle(128);
      chk(wiper_code == 8'd128, "R8 no write while locked", int'(wiper_code), 128);
      chk(standby && !miso_oe, "R7 deselected", int'({standby, miso_oe}), 2);

      // R1 R2: write wiper, MSB first
      xfer(16'h20_5A, 16, 1'b1, 1'b0, 1'b0, 8'h00, "R1 write");
      settle(8'h5A);
      chk(wiper_code == 8'h5A, "R1 R2 write wiper", int'(wiper_code), 8'h5A);

      // R4 R5: read back in reset push-pull mode
      xfer(16'h10_00, 16, 1'b1, 1'b1, 1'b0, 8'h5A, "R4 R5 push-pull read");
      settle(8'h5A);
      // R9: mode register reads 0
      xfer(16'h11_00, 16, 1'b1, 1'b1, 1'b0, 8'h00, "R9 mode reset read");
      settle(8'h5A);

      // R11 extremes
      xfer(16'h20_FF, 16, 1'b1, 1'b0, 1'b0, 8'h00, "R11 write");
      settle(255);
      chk(tap_sel[255] && tap_sel[0] == 1'b0, "R11 top tap", int'(tap_sel[255]), 1);
      xfer(16'h20_00, 16, 1'b1, 1'b0, 1'b0, 8'h00, "R11 write");
      settle(0);
      chk(tap_sel[0] && tap_sel[255] == 1'b0, "R11 bottom tap", int'(tap_sel[0]), 1);

      // R3: aborted frames
      xfer(16'h20_77, 12, 1'b1, 1'b0, 1'b0, 8'h00, "R3 abort 12");
      settle(0);
      chk(wiper_code == 8'h00, "R3 abort 12 bits", int'(wiper_code), 0);
      xfer(16'h20_77, 15, 1'b1, 1'b0, 1'b0, 8'h00, "R3 abort 15");
      settle(0);
      chk(wiper_code == 8'h00, "R3 abort 15 bits", int'(wiper_code), 0);

      // R10: undefined opcode / address
      xfer(16'h30_44, 16, 1'b1, 1'b0, 1'b0, 8'h00, "R10 bad opcode quiet");
      settle(0);
      xfer(16'h25_44, 16, 1'b1, 1'b0, 1'b0, 8'h00, "R10 bad address quiet");
      settle(0);
      xfer(16'h15_00, 16, 1'b1, 1'b0, 1'b0, 8'h00, "R10 bad read address quiet");
      settle(0);
      xfer(16'h11_00, 16, 1'b1, 1'b1, 1'b0, 8'h00, "R10 mode untouched");
      settle(0);

      // R5 R6: open-drain mode
      xfer(16'h20_A5, 16, 1'b1, 1'b0, 1'b0, 8'h00, "R2 write");
      settle(8'hA5);
      xfer(16'h21_02, 16, 1'b1, 1'b0, 1'b0, 8'h00, "R5 set open-drain");
      settle(8'hA5);
      xfer(16'h10_00, 16, 1'b1, 1'b1, 1'b1, 8'hA5, "R6 open-drain read");
      settle(8'hA5);
      xfer(16'h11_00, 16, 1'b1, 1'b1, 1'b1, 8'h02, "R6 open-drain mode read");
      settle(8'hA5);

      // R5 R6: back to push-pull
      xfer(16'h21_00, 16, 1'b1, 1'b0, 1'b0, 8'h00, "R5 set push-pull");
      settle(8'hA5);
      xfer(16'h10_00, 16, 1'b1, 1'b1, 1'b0, 8'hA5, "R6 push-pull read");
      settle(8'hA5);
      wclk(4);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule